// File: doc/BRIEF.md
# Filtered Quadrature Encoder Channel

This block turns one encoder's single-ended A, B and index (Z) feedback lines into a position count. All three lines are first brought into the clock domain by a two-stage synchronizer. A digital glitch filter then removes short spikes picked up from the drive electronics. Each filtered A or B edge moves a 32-bit two's complement position counter up or down by one, so the count advances four times per quadrature cycle. The direction comes from which of A and B leads.

The Z line pulses low once per revolution and is used for precise homing. On the falling edge of the filtered Z line, the current count is copied into an index register and a flag is raised. The host acknowledges the flag with a pulse. A synchronous clear zeroes the counter and the error flag. A jump in which both A and B change at once cannot be decoded: it is flagged as an error and leaves the count alone.

With the default filter length of 8 clocks at a 100 MHz system clock, edges that arrive 250 ns apart (4 MHz) still pass comfortably. One instance is placed per axis.

Top module: `qenc_channel`

## Requirements
- R1: After reset, `pos`, `idx_pos`, `idx_seen` and `err` are all zero.
- R2: With `{A,B}` stepping through 00, 10, 11, 01 and back to 00 (A leading B), each filtered transition adds one to `pos`.
- R3: Stepping the same states in reverse order (B leading A) subtracts one per transition.
- R4: A filtered transition in which A and B both change leaves `pos` unchanged and sets `err`. `err` stays set until `clr`.
- R5: A change on A, B or Z that lasts fewer than STABLE_CLKS clocks (default 8) is ignored. A change held for at least STABLE_CLKS clocks is accepted. Its effect on `pos` appears STABLE_CLKS+3 rising edges after the change is applied.
- R6: A falling edge of filtered Z copies `pos` into `idx_pos` and sets `idx_seen`.
- R7: A one-cycle `idx_ack` clears `idx_seen`. If a new index edge arrives in the same cycle, setting the flag wins.
- R8: While `clr` is high, `pos` and `err` are held at zero, even if a valid transition is decoded in the same cycle.
- R9: `pos` wraps in two's complement: one down step from zero gives 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_z | input | 1 | Index line, pulses low once per revolution |
| clr | input | 1 | Synchronous counter and error clear |
| idx_ack | input | 1 | Host acknowledge; clears the index flag |
| pos | output | 32 | Position count, two's complement |
| idx_pos | output | 32 | Position captured at the last index edge |
| idx_seen | output | 1 | Index edge seen since the last acknowledge |
| err | output | 1 | Sticky illegal-transition flag |

## Verification
A level change applied before rising edge e0 reaches the filter output at edge e0+STABLE_CLKS+1. It reaches `pos`, `idx_pos`, `idx_seen` and `err` one edge later. Counting e0, that makes STABLE_CLKS+3 rising edges in all.

The bench drives inputs on falling edges and holds every level for STABLE_CLKS+4 edges. It samples on the following falling edge, so each result is read after it is due and before the next stimulus. `clr` and `idx_ack` act one edge after they are driven, and their results are sampled on the next falling edge.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    // ab[1] is phase A, ab[0] is phase B
    function automatic step_e classify(input logic [1:0] prev_ab, input logic [1:0] cur_ab);
        if (prev_ab == cur_ab)
            return STEP_NONE;
        else if ((prev_ab ^ cur_ab) == 2'b11)
            return STEP_BAD;
        else if ((prev_ab[0] ^ cur_ab[1]) == 1'b1)
            return STEP_UP;
        else
            return STEP_DOWN;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{s1: INIT, s2: INIT};
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/qenc_filter.sv
module qenc_filter #(
    parameter int   STABLE_CLKS = 8,
    parameter logic INIT        = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE_CLKS + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(STABLE_CLKS - 1)) begin
            st_d.lvl = din;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{lvl: INIT, cnt: '0};
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;

    // R5
    filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> ($past(din) != $past(st_q.lvl)));

    // R5
    filter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din == st_q.lvl) |=> (st_q.cnt == '0));
endmodule

// File: rtl/qenc_core.sv
module qenc_core
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_f,
    input  logic             b_f,
    input  logic             z_f,
    input  logic             clr,
    input  logic             idx_ack,
    output logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] idx_pos,
    output logic             idx_seen,
    output logic             err
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] idx;
        logic             seen;
        logic             err;
        logic [1:0]       ab_prev;
        logic             z_prev;
    } core_t;

    core_t st_d, st_q;
    step_e step;
    logic  z_fall;

    always_comb begin
        st_d         = st_q;
        step         = classify(st_q.ab_prev, {a_f, b_f});
        z_fall       = st_q.z_prev & ~z_f;
        st_d.ab_prev = {a_f, b_f};
        st_d.z_prev  = z_f;

        unique case (step)
            STEP_UP:   st_d.pos = st_q.pos + CNT_W'(1);
            STEP_DOWN: st_d.pos = st_q.pos - CNT_W'(1);
            STEP_BAD:  st_d.err = 1'b1;
            default:   ;
        endcase

        if (clr) begin
            st_d.pos = '0;
            st_d.err = 1'b0;
        end

        if (idx_ack) st_d.seen = 1'b0;
        if (z_fall) begin
            st_d.idx  = st_q.pos;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.z_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos      = st_q.pos;
    assign idx_pos  = st_q.idx;
    assign idx_seen = st_q.seen;
    assign err      = st_q.err;

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.pos == '0 && !st_q.err));

    // R4
    bad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_BAD && !clr) |=> (st_q.err && $stable(st_q.pos)));

    // R2 R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (st_q.pos == $past(st_q.pos) ||
                  st_q.pos == $past(st_q.pos) + CNT_W'(1) ||
                  st_q.pos == $past(st_q.pos) - CNT_W'(1)));

    // R6
    idx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_fall |=> (st_q.seen && st_q.idx == $past(st_q.pos)));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ack && !z_fall) |=> !st_q.seen);
endmodule

// File: rtl/qenc_channel.sv
module qenc_channel #(
    parameter int CNT_W       = 32,
    parameter int STABLE_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_z,
    input  logic             clr,
    input  logic             idx_ack,
    output logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] idx_pos,
    output logic             idx_seen,
    output logic             err
);
    localparam int         NLINES = 3;
    localparam logic [2:0] IDLE   = 3'b100; // {z, b, a}: index line idles high

    logic [NLINES-1:0] raw, synced, filtered;

    assign raw = {enc_z, enc_b, enc_a};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        qenc_sync #(.INIT(IDLE[i])) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .dout (synced[i])
        );
        qenc_filter #(.STABLE_CLKS(STABLE_CLKS), .INIT(IDLE[i])) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (synced[i]),
            .dout (filtered[i])
        );
    end

    qenc_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_f     (filtered[0]),
        .b_f     (filtered[1]),
        .z_f     (filtered[2]),
        .clr     (clr),
        .idx_ack (idx_ack),
        .pos     (pos),
        .idx_pos (idx_pos),
        .idx_seen(idx_seen),
        .err     (err)
    );
endmodule

// File: tb/qenc_channel_test.sv
`timescale 1ns/1ps
module qenc_channel_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b1;
    logic        clr = 1'b0, idx_ack = 1'b0;
    logic [31:0] pos, idx_pos;
    logic        idx_seen, err;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [31:0] exp_pos = 0, exp_idx = 0;
    bit          exp_err = 0, exp_seen = 0;
    int          phase = 0;

    always #2.5 clk = ~clk;

    qenc_channel #(.CNT_W(32), .STABLE_CLKS(N)) uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
        .clr(clr), .idx_ack(idx_ack), .pos(pos), .idx_pos(idx_pos),
        .idx_seen(idx_seen), .err(err)
    );

    // phase order for A leading B: {A,B} = 00,10,11,01
    function automatic logic [1:0] ab_of(input int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic settle();
        repeat (N + 4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        check({req, " pos"}, pos, exp_pos);
        check({req, " err"}, {31'd0, err}, {31'd0, exp_err});
        check({req, " idx_seen"}, {31'd0, idx_seen}, {31'd0, exp_seen});
        check({req, " idx_pos"}, idx_pos, exp_idx);
    endtask

    // kind: 0 up, 1 down, 2 illegal, 3 hold
    task automatic move(input int kind);
        int nxt;
        case (kind)
            0: nxt = phase + 1;
            1: nxt = phase + 3;
            2: nxt = phase + 2;
            default: nxt = phase;
        endcase
        case ((nxt - phase) & 3)
            1: exp_pos = exp_pos + 32'd1;
            3: exp_pos = exp_pos - 32'd1;
            2: exp_err = 1'b1;
            default: ;
        endcase
        phase = nxt & 3;
        {enc_a, enc_b} = ab_of(phase);
        settle();
    endtask

    task automatic index_pulse();
        enc_z = 1'b0;
        settle();
        enc_z = 1'b1;
        settle();
        exp_idx  = exp_pos;
        exp_seen = 1'b1;
    endtask

    task automatic ack();
        idx_ack = 1'b1;
        @(negedge clk);
        idx_ack = 1'b0;
        @(negedge clk);
        exp_seen = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R9: wrap below zero
        move(1);
        check("R9 wrap", pos, 32'hFFFF_FFFF);
        move(0);
        check("R2 up from -1", pos, 32'd0);

        // R2: full forward cycle
        for (int i = 0; i < 4; i++) move(0);
        check("R2 four up", pos, 32'd4);
        // R3: full reverse cycle
        for (int i = 0; i < 4; i++) move(1);
        check("R3 four down", pos, 32'd0);

        // R5: short glitch on A is rejected
        enc_a = ~enc_a;
        repeat (N - 1) @(negedge clk);
        enc_a = ~enc_a;
        settle();
        check_all("R5 short glitch");
        // R5: short low glitch on Z is rejected
        enc_z = 1'b0;
        repeat (N - 1) @(negedge clk);
        enc_z = 1'b1;
        settle();
        check("R5 Z glitch idx_seen", {31'd0, idx_seen}, 32'd0);
        // R5: change held exactly N clocks is accepted
        enc_a = ~enc_a;
        repeat (N) @(negedge clk);
        enc_b = ~enc_b;
        exp_pos = exp_pos + 32'd1;
        phase = 2;
        settle();
        exp_pos = exp_pos + 32'd1;
        check("R5 held N clocks", pos, exp_pos);

        // R6 / R7
        move(0);
        index_pulse();
        check_all("R6 index capture");
        ack();
        check_all("R7 ack clears");

        // R4 illegal jump
        move(2);
        check_all("R4 illegal");
        move(0);
        check_all("R4 err sticky");

        // R8 clear with counting in progress
        clr = 1'b1;
        exp_pos = 0;
        exp_err = 0;
        {enc_a, enc_b} = ab_of(phase + 1);
        phase = (phase + 1) & 3;
        settle();
        check_all("R8 clr priority");
        clr = 1'b0;
        @(negedge clk);
        check_all("R8 after clr");

        // random walk with directed index and acknowledge
        for (int s = 0; s < 80; s++) begin
            int r = int'($urandom % 10);
            if (r < 4)      move(0);
            else if (r < 8) move(1);
            else if (r < 9) move(3);
            else            move(2);
            check_all("R2 R3 R4 random");
            if (s % 20 == 10) begin
                index_pulse();
                check_all("R6 random index");
                ack();
                check("R7 random ack", {31'd0, idx_seen}, 32'd0);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule